// File: doc/BRIEF.md
# Receive FIFO with Programmable Fill Triggers

This block buffers received bytes for a serial port in a 16-entry first-in, first-out store. A deserializer pushes each completed byte with a write strobe. The CPU or a DMA engine pops bytes with a read strobe. The block reports how many bytes it holds, and whether it is empty or full.

Two fill thresholds are compared against the stored count. The first sets a sticky receive-ready flag. A 2-bit code selects its level, and the levels differ between asynchronous and clock-synchronous operation. Software acknowledges the flag with a clear pulse.

The second threshold drives a flow-control output that asks the far end to stop sending. A 3-bit code selects its level. If a write arrives while the store is full, the byte is dropped and a sticky overrun output is raised.

When a DMA engine drains the store in clock-synchronous operation, the ready level should be 1. Otherwise, bytes left below the level have to be collected by the CPU.

Top module: `rx_fifo_trig`

## Requirements
- R1: Accepted bytes come out on `rd_data` in write order. `rd_data` shows the popped byte from the edge of the accepted read onward. `count` equals accepted writes minus accepted reads, within 0..16. `empty` is high exactly at count 0 and `full` exactly at count 16.
- R2: A write while `full` is high is dropped, and `count` is not increased by it. The same edge sets `overrun`, which stays high until reset.
- R3: A read while `empty` is high leaves `count` unchanged, and `rd_data` keeps its previous value.
- R4: When the store is neither empty nor full, a read and a write in the same cycle leave `count` unchanged. The written byte is queued behind the others.
- R5: With `sync_mode`=0, `rx_trig` values 0, 1, 2 and 3 select ready levels 1, 4, 8 and 14. `rdf` becomes 1 one clock after `count` is at or above the level.
- R6: With `sync_mode`=1, `rx_trig` values 0, 1, 2 and 3 select ready levels 1, 2, 8 and 14, with the same timing as R5.
- R7: `rdf` stays 1 until a `rdf_clr` pulse. The clear takes effect one clock later, but only if `count` is below the ready level in the clear cycle. Otherwise `rdf` stays 1.
- R8: `rts_trig` values 0..7 select flow-control levels 15, 1, 4, 6, 8, 10, 12 and 14. `rts` becomes 1 one clock after `count` exceeds the level, and 0 one clock after `count` is at or below it.
- R9: While `rst_n` is low, the following hold at the next edge: `count` 0, `empty` 1, `full` 0, `rdf` 0, `rts` 0, `overrun` 0 and `rd_data` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Push strobe from the deserializer |
| wr_data | input | 8 | Byte to push |
| rd_en | input | 1 | Pop strobe from CPU or DMA |
| sync_mode | input | 1 | 0 asynchronous, 1 clock-synchronous level table |
| rx_trig | input | 2 | Ready-level select code |
| rts_trig | input | 3 | Flow-control level select code |
| rdf_clr | input | 1 | Clear pulse for the ready flag |
| rd_data | output | 8 | Last popped byte |
| count | output | 5 | Bytes stored |
| rdf | output | 1 | Sticky receive-ready flag |
| rts | output | 1 | Flow-control request |
| empty | output | 1 | Count is zero |
| full | output | 1 | Count is 16 |
| overrun | output | 1 | Sticky dropped-write indication |

## Verification
A push and a pop can fall in the same cycle, and the count arithmetic must then balance. This is provoked in the middle of the store, at the full boundary where the push is dropped, and at the empty boundary where only the push succeeds. A bench-side model applies the acceptance rules of R1 to R4. It is compared against `count`, `full`, `overrun` and the popped byte order after every edge. The ready-flag clear is also issued in cycles where the count is still at or above the level, and the flag must survive it.

// File: rtl/rx_fifo_trig.sv
module rx_fifo_trig #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [DW-1:0]              wr_data,
  input  logic                       rd_en,
  input  logic                       sync_mode,
  input  logic [1:0]                 rx_trig,
  input  logic [2:0]                 rts_trig,
  input  logic                       rdf_clr,
  output logic [DW-1:0]              rd_data,
  output logic [$clog2(DEPTH):0]     count,
  output logic                       rdf,
  output logic                       rts,
  output logic                       empty,
  output logic                       full,
  output logic                       overrun
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt, rx_lvl, rts_lvl;
  logic [DW-1:0] rd_q;
  logic          rdf_q, rts_q, ovr_q;

  assign full  = cnt == CW'(DEPTH);
  assign empty = cnt == '0;

  wire push = wr_en & ~full;
  wire pop  = rd_en & ~empty;

  always_comb begin
    case (rx_trig)
      2'd0:    rx_lvl = CW'(1);
      2'd1:    rx_lvl = sync_mode ? CW'(2) : CW'(4);
      2'd2:    rx_lvl = CW'(8);
      default: rx_lvl = CW'(14);
    endcase
  end

  always_comb begin
    case (rts_trig)
      3'd0:    rts_lvl = CW'(15);
      3'd1:    rts_lvl = CW'(1);
      3'd2:    rts_lvl = CW'(4);
      3'd3:    rts_lvl = CW'(6);
      3'd4:    rts_lvl = CW'(8);
      3'd5:    rts_lvl = CW'(10);
      3'd6:    rts_lvl = CW'(12);
      default: rts_lvl = CW'(14);
    endcase
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      cnt   <= '0;
      rd_q  <= '0;
      rdf_q <= 1'b0;
      rts_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop) begin
        rd_q <= mem[rp];
        rp   <= rp + 1'b1;
      end
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      if (wr_en && full) ovr_q <= 1'b1;
      rdf_q <= (cnt >= rx_lvl) | (rdf_q & ~rdf_clr);
      rts_q <= cnt > rts_lvl;
    end
  end

  assign rd_data = rd_q;
  assign count   = cnt;
  assign rdf     = rdf_q;
  assign rts     = rts_q;
  assign overrun = ovr_q;
endmodule

module rx_fifo_trig_chk #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_en,
  input logic                   rd_en,
  input logic                   rdf_clr,
  input logic [DW-1:0]          rd_data,
  input logic [$clog2(DEPTH):0] count,
  input logic                   rdf,
  input logic                   rts,
  input logic                   empty,
  input logic                   full,
  input logic                   overrun
);
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n) count <= DEPTH); // R1
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n) full && wr_en && !rd_en |=> full && overrun); // R2
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) overrun |=> overrun); // R2
  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n) empty && rd_en && !wr_en |=> $stable(rd_data) && empty); // R3
  AST_RW_BALANCE: assert property (@(posedge clk) disable iff (!rst_n) !empty && !full && wr_en && rd_en |=> $stable(count)); // R4
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n) rdf && !rdf_clr |=> rdf); // R7
  AST_RTS_IDLE: assert property (@(posedge clk) disable iff (!rst_n) count == 0 |=> !rts); // R8
endmodule

bind rx_fifo_trig rx_fifo_trig_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .rdf_clr(rdf_clr),
  .rd_data(rd_data), .count(count), .rdf(rdf), .rts(rts),
  .empty(empty), .full(full), .overrun(overrun)
);

// File: tb/test_rx_fifo_trig.sv
`timescale 1ns/1ps
module test_rx_fifo_trig;
  logic       clk = 0, rst_n = 0;
  logic       wr_en = 0, rd_en = 0, sync_mode = 0, rdf_clr = 0;
  logic [7:0] wr_data = 0;
  logic [1:0] rx_trig = 0;
  logic [2:0] rts_trig = 0;
  logic [7:0] rd_data;
  logic [4:0] count;
  logic       rdf, rts, empty, full, overrun;

  rx_fifo_trig i_rx_fifo_trig (.*);

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  bit mon_on = 0;
  logic [7:0] store_q[$];
  logic [7:0] exp_rd_q[$];
  logic [7:0] last_rd = 0;
  int  m_cnt = 0;
  bit  m_rdf = 0, m_rts = 0, m_ovr = 0;
  logic [7:0] seed = 8'h5a;

  function automatic int rx_level(bit s, logic [1:0] c);
    case (c)
      2'd0: return 1;
      2'd1: return s ? 2 : 4;
      2'd2: return 8;
      default: return 14;
    endcase
  endfunction

  function automatic int rts_level(logic [2:0] c);
    case (c)
      3'd0: return 15;
      3'd1: return 1;
      3'd2: return 4;
      3'd3: return 6;
      3'd4: return 8;
      3'd5: return 10;
      3'd6: return 12;
      default: return 14;
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(bit w, bit r, bit c);
    bit aw, ar;
    wr_en = w; rd_en = r; rdf_clr = c;
    if (w) begin wr_data = seed; seed = seed * 8'd5 + 8'd3; end
    @(posedge clk);
    aw = w && m_cnt < 16;
    ar = r && m_cnt > 0;
    m_rdf = (m_cnt >= rx_level(sync_mode, rx_trig)) || (m_rdf && !c);
    m_rts = m_cnt > rts_level(rts_trig);
    if (w && m_cnt == 16) m_ovr = 1;
    if (ar) exp_rd_q.push_back(store_q.pop_front());
    if (aw) store_q.push_back(wr_data);
    m_cnt = m_cnt + int'(aw) - int'(ar);
    #1;
  endtask

  always @(negedge clk) if (mon_on) begin
    check("R1 count", count, m_cnt);
    check("R1 empty", empty, m_cnt == 0);
    check("R1 full", full, m_cnt == 16);
    check("R2 overrun", overrun, m_ovr);
    check("R5/R6/R7 rdf", rdf, m_rdf);
    check("R8 rts", rts, m_rts);
    if (exp_rd_q.size() > 0) last_rd = exp_rd_q.pop_front();
    check("R1/R3 rd_data", rd_data, last_rd);
  end

  initial begin
    #(4 * 200000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 count", count, 0);
    check("R9 empty", empty, 1);
    check("R9 full", full, 0);
    check("R9 rdf", rdf, 0);
    check("R9 rts", rts, 0);
    check("R9 overrun", overrun, 0);
    check("R9 rd_data", rd_data, 0);
    rst_n = 1; mon_on = 1;

    // R3: read while empty; R4 at empty boundary (only push lands)
    step(0, 1, 0); step(0, 1, 0); step(1, 1, 0);
    step(0, 1, 0); step(0, 0, 0);

    // R5 async level 4, R8 level 4; fill, R4 mid-store, R2 overflow
    rx_trig = 2'd1; rts_trig = 3'd2;
    for (int i = 0; i < 6; i++) step(1, 0, 0);
    step(0, 0, 1);                       // R7 clear ignored, count >= 4
    step(0, 0, 0);
    step(1, 1, 0); step(1, 1, 0);        // R4 balanced
    for (int i = 0; i < 12; i++) step(1, 0, 0);
    step(1, 0, 0); step(1, 1, 0);        // R2 drop, full with read
    step(0, 0, 0);
    for (int i = 0; i < 17; i++) step(0, 1, 0);
    step(0, 0, 1); step(0, 0, 0);        // R7 clear works
    step(0, 1, 0); step(0, 0, 0);        // R3

    // R5, R6, R8: sweep codes and modes
    for (int s = 0; s < 2; s++)
      for (int k = 0; k < 8; k++) begin
        sync_mode = s[0]; rx_trig = k[1:0]; rts_trig = k[2:0];
        for (int i = 0; i < 16; i++) step(1, 0, (i % 5) == 4);
        step(0, 0, 1);
        for (int i = 0; i < 16; i++) step(0, 1, 0);
        step(0, 0, 1); step(0, 0, 0); step(0, 0, 0);
      end

    // R6 sync level 2 exactly at threshold
    sync_mode = 1; rx_trig = 2'd1; rts_trig = 3'd1;
    step(1, 0, 0); step(0, 0, 0); step(1, 0, 0); step(0, 0, 0); step(0, 0, 0);
    step(0, 1, 1); step(0, 0, 1); step(0, 1, 0); step(0, 0, 1); step(0, 0, 0);

    mon_on = 0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule